// File: doc/BRIEF.md
# Double-Buffer DMA Handshake Controller

This block arbitrates a pair of position-data buffers between the network side, which fills one buffer, and a host DMA engine, which drains the other. On the rising edge of the frame-end strobe it exchanges the two buffers and starts a DMA request. It does this only if the host has acknowledged the previous transfer. A frame end that arrives while an acknowledgement is still outstanding leaves the buffers where they are and is counted as a missed frame.

The host acknowledges by reading a single status word. That read returns the missed-frame count and, in the same clock edge, clears the count and the outstanding acknowledgement, so the returned value and the acknowledgement always belong together. A watchdog limits how long a DMA request may wait for completion. When it expires, the request is withdrawn, the transfer counts as missed and the buffers are freed for the next frame. The position read path forces the words of inactive nodes to zero. The node-status mask is single buffered, so host software must fetch it within 100 microseconds of the interrupt.

Top module: `dbuf_dma_ctrl`

## Requirements
- R1: Only a low-to-high transition of `frame_end` can cause a swap. A level held high, or a falling edge, changes neither `buf_sel` nor `irq`.
- R2: On a rising frame end with no acknowledgement outstanding, the block does three things at the next clock edge: it inverts `buf_sel`, it raises `dma_req`, and it pulses `irq` high for exactly one cycle. It then marks an acknowledgement as outstanding.
- R3: On a rising frame end while an acknowledgement is outstanding and no read occurs in the same cycle, the missed count goes up by one, and `buf_sel` and `irq` stay unchanged.
- R4: The missed count saturates at 2^CNT_W-1 and does not wrap.
- R5: A read (`stat_rd` high at an edge) places the missed count held before that edge on `stat_rdata`, which is visible after the edge and held until the next read. The same edge clears the count and the outstanding acknowledgement, so a read with no misses since the last read returns zero.
- R6: When a read and a rising frame end fall in the same cycle, the read acknowledges first: the swap proceeds, and `stat_rdata` returns the count held before that edge.
- R7: `dma_req` stays high until `dma_done` is sampled high. `dma_done` while no request is active has no effect.
- R8: If `dma_req` stays high for WDOG_CYCLES cycles without `dma_done`, the block drops the request, adds one to the missed count and clears the outstanding acknowledgement, so the next rising frame end swaps.
- R9: `pos_rdata` equals `pos_raw` when `node_live` is high and is zero when it is low (combinational).
- R10: After reset, `buf_sel`, `dma_req`, `irq` and `stat_rdata` are 0, the count is 0 and no acknowledgement is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | Frame-end level; its rising edge is the event |
| stat_rd | input | 1 | Host read strobe for the status word (acknowledges) |
| stat_rdata | output | CNT_W | Missed-frame count captured by the last read |
| buf_sel | output | 1 | Buffer currently owned by the host side |
| dma_req | output | 1 | DMA transfer request |
| dma_done | input | 1 | DMA transfer complete |
| irq | output | 1 | One-cycle interrupt on each swap |
| node_live | input | 1 | Node addressed by the position read is active |
| pos_raw | input | POS_W | Position word from the buffer memory |
| pos_rdata | output | POS_W | Position word returned to the host |

## Verification
The checker assumes that `frame_end` and `stat_rd` are clean synchronous levels, with no value other than 0 or 1 in the cycles after reset. It also assumes that `dma_done` is a level the DMA engine may assert at any time, including when no request is active. The stimulus changes every input one time unit after the rising edge and holds `frame_end` low across reset. This keeps the two-cycle look-back on the frame edge well defined. Reads, frame ends and completions are placed at chosen cycles, including a read that coincides with a frame end. Each scenario drains or completes the outstanding DMA request before the next one, so that only the scenario that tests the watchdog lets it expire.

// File: rtl/dbuf_dma_ctrl.sv
module dbuf_dma_ctrl #(
  parameter int CNT_W       = 8,
  parameter int WDOG_CYCLES = 64,
  parameter int POS_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             stat_rd,
  output logic [CNT_W-1:0] stat_rdata,
  output logic             buf_sel,
  output logic             dma_req,
  input  logic             dma_done,
  output logic             irq,
  input  logic             node_live,
  input  logic [POS_W-1:0] pos_raw,
  output logic [POS_W-1:0] pos_rdata
);

  localparam int WD_W = $clog2(WDOG_CYCLES) + 1;
  localparam logic [WD_W-1:0]  WD_LAST = WD_W'(WDOG_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fe_q;
  logic             ack_pend;
  logic [CNT_W-1:0] miss_cnt;
  logic [WD_W-1:0]  wd_cnt;

  logic             fe_rise, acked, do_swap, fe_miss, wd_exp;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W:0]   cnt_sum;

  assign fe_rise  = frame_end & ~fe_q;
  assign acked    = ~ack_pend | stat_rd;
  assign do_swap  = fe_rise & acked;
  assign fe_miss  = fe_rise & ~acked;
  assign wd_exp   = dma_req & ~dma_done & (wd_cnt == WD_LAST);
  assign cnt_base = stat_rd ? '0 : miss_cnt;
  assign cnt_sum  = {1'b0, cnt_base} + {{CNT_W{1'b0}}, fe_miss} + {{CNT_W{1'b0}}, wd_exp};

  assign pos_rdata = node_live ? pos_raw : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_q       <= 1'b0;
      ack_pend   <= 1'b0;
      miss_cnt   <= '0;
      wd_cnt     <= '0;
      stat_rdata <= '0;
      buf_sel    <= 1'b0;
      dma_req    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      fe_q <= frame_end;
      irq  <= do_swap;

      if (stat_rd)
        stat_rdata <= miss_cnt;

      miss_cnt <= cnt_sum[CNT_W] ? CNT_MAX : cnt_sum[CNT_W-1:0];

      if (do_swap) begin
        buf_sel  <= ~buf_sel;
        ack_pend <= 1'b1;
      end else if (stat_rd || wd_exp) begin
        ack_pend <= 1'b0;
      end

      if (do_swap)
        dma_req <= 1'b1;
      else if (dma_done || wd_exp)
        dma_req <= 1'b0;

      if (do_swap || !dma_req)
        wd_cnt <= '0;
      else if (!wd_exp)
        wd_cnt <= wd_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dbuf_dma_ctrl_chk.sv
module dbuf_dma_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_end,
  input logic             stat_rd,
  input logic [CNT_W-1:0] stat_rdata,
  input logic             buf_sel,
  input logic             dma_req,
  input logic             dma_done,
  input logic             irq,
  input logic             ack_pend,
  input logic [CNT_W-1:0] miss_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_SWAP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_sel != $past(buf_sel)) |-> ($past(frame_end) && !$past(frame_end, 2))); // R1

  AST_SWAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_sel != $past(buf_sel)) |-> (irq && dma_req && ack_pend)); // R2

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R2

  AST_PENDING_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pend && !stat_rd && frame_end && !$past(frame_end)) |=> ($stable(buf_sel) && !irq)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == CNT_MAX && !stat_rd) |=> (miss_cnt == CNT_MAX)); // R4

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (stat_rdata == $past(miss_cnt))); // R5

  AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!ack_pend || (buf_sel != $past(buf_sel)))); // R6

  AST_REQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> ($past(dma_done) || (miss_cnt != '0))); // R7 R8

endmodule

bind dbuf_dma_ctrl dbuf_dma_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .stat_rd   (stat_rd),
  .stat_rdata(stat_rdata),
  .buf_sel   (buf_sel),
  .dma_req   (dma_req),
  .dma_done  (dma_done),
  .irq       (irq),
  .ack_pend  (ack_pend),
  .miss_cnt  (miss_cnt)
);

// File: tb/dbuf_dma_ctrl_tb.sv
`timescale 1ns/1ps
module dbuf_dma_ctrl_tb;

  localparam int CNT_W = 8;
  localparam int WD    = 64;
  localparam int POS_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_end = 1'b0;
  logic             stat_rd = 1'b0;
  logic [CNT_W-1:0] stat_rdata;
  logic             buf_sel;
  logic             dma_req;
  logic             dma_done = 1'b0;
  logic             irq;
  logic             node_live = 1'b0;
  logic [POS_W-1:0] pos_raw = '0;
  logic [POS_W-1:0] pos_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic exp_sel = 1'b0;

  always #2 clk = ~clk;

  dbuf_dma_ctrl #(.CNT_W(CNT_W), .WDOG_CYCLES(WD), .POS_W(POS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .buf_sel(buf_sel), .dma_req(dma_req),
    .dma_done(dma_done), .irq(irq), .node_live(node_live),
    .pos_raw(pos_raw), .pos_rdata(pos_rdata)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fe_pulse();
    frame_end = 1'b1; step();
    frame_end = 1'b0; step();
  endtask

  task automatic host_read();
    stat_rd = 1'b1; step();
    stat_rd = 1'b0;
  endtask

  task automatic finish_dma();
    dma_done = 1'b1; step();
    dma_done = 1'b0;
    check("R7 req cleared by done", dma_req, 0);
  endtask

  task automatic t_reset();
    check("R10 buf_sel", buf_sel, 0);
    check("R10 dma_req", dma_req, 0);
    check("R10 irq", irq, 0);
    check("R10 stat_rdata", stat_rdata, 0);
    host_read();
    check("R10 count zero", stat_rdata, 0);
  endtask

  task automatic t_swap();
    frame_end = 1'b1; step();
    exp_sel = ~exp_sel;
    check("R2 sel toggled", buf_sel, exp_sel);
    check("R2 irq", irq, 1);
    check("R2 req", dma_req, 1);
    step();
    check("R1 held high no irq", irq, 0);
    check("R1 held high no swap", buf_sel, exp_sel);
    check("R7 req held", dma_req, 1);
    frame_end = 1'b0; step();
    check("R1 fall no swap", buf_sel, exp_sel);
    finish_dma();
    dma_done = 1'b1; step(); dma_done = 1'b0;
    check("R7 done without req", dma_req, 0);
    check("R7 done without req sel", buf_sel, exp_sel);
  endtask

  task automatic t_miss();
    frame_end = 1'b1; step();
    check("R3 sel unchanged", buf_sel, exp_sel);
    check("R3 no irq", irq, 0);
    frame_end = 1'b0; step();
    host_read();
    check("R5 read count one", stat_rdata, 1);
    step();
    check("R5 rdata held", stat_rdata, 1);
    host_read();
    check("R5 reads zero", stat_rdata, 0);
  endtask

  task automatic t_collide();
    fe_pulse();
    exp_sel = ~exp_sel;
    check("R2 swap after ack", buf_sel, exp_sel);
    finish_dma();
    fe_pulse();
    check("R3 miss keeps sel", buf_sel, exp_sel);
    frame_end = 1'b1; stat_rd = 1'b1; step();
    exp_sel = ~exp_sel;
    check("R6 swap with read", buf_sel, exp_sel);
    check("R6 irq with read", irq, 1);
    check("R6 pre-clear count", stat_rdata, 1);
    frame_end = 1'b0; stat_rd = 1'b0; step();
    host_read();
    check("R6 count cleared", stat_rdata, 0);
    finish_dma();
  endtask

  task automatic t_wdog();
    frame_end = 1'b1; step();
    exp_sel = ~exp_sel;
    check("R8 swap", buf_sel, exp_sel);
    frame_end = 1'b0;
    for (int k = 1; k <= WD; k++) begin
      step();
      if (k == WD - 1) check("R8 req before expiry", dma_req, 1);
    end
    check("R8 req dropped", dma_req, 0);
    fe_pulse();
    exp_sel = ~exp_sel;
    check("R8 pending cleared", buf_sel, exp_sel);
    host_read();
    check("R8 expiry counted", stat_rdata, 1);
    finish_dma();
  endtask

  task automatic t_sat();
    fe_pulse();
    exp_sel = ~exp_sel;
    check("R4 swap", buf_sel, exp_sel);
    finish_dma();
    for (int i = 0; i < 260; i++) fe_pulse();
    check("R4 sel frozen", buf_sel, exp_sel);
    host_read();
    check("R4 saturated", stat_rdata, 255);
    host_read();
    check("R4 cleared", stat_rdata, 0);
  endtask

  task automatic t_pos();
    pos_raw = 32'hDEAD_BEEF; node_live = 1'b0; #1;
    check("R9 inactive zero", pos_rdata, 0);
    node_live = 1'b1; #1;
    check("R9 active pass", pos_rdata, 32'hDEAD_BEEF);
    pos_raw = 32'h0000_1234; #1;
    check("R9 active pass 2", pos_rdata, 32'h0000_1234);
    node_live = 1'b0; #1;
    check("R9 inactive zero 2", pos_rdata, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_swap();
    t_miss();
    t_collide();
    t_wdog();
    t_sat();
    t_pos();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule